// File: doc/BRIEF.md
# Firmware Region Write-Protect Control Register

This block is a single byte-wide control register that governs host access to the firmware flash region. Software reads and writes it over a simple register bus with a select, a write strobe, write data and read data. It holds a firmware write-enable bit, a two-bit read-policy field, a sticky lock bit and a management-mode protect bit. It also mirrors an externally supplied top-swap status bit.

The register drives two outputs. The first is a write-permit level that the flash path uses to let host writes through to the firmware region. The second is a one-cycle system-management interrupt pulse. The pulse fires when software turns firmware writes on while the lock is in force, so that management code can check the change. The lock bit can only be set; a platform reset clears it. The protect bit accepts only the first write after reset. When the protect bit is set, writes are permitted only while every processor reports that it is in management mode.

Top module: `fw_wp_ctrl`

## Requirements
- R1: After reset the register reads 0x20 with top_swap_i low: write-enable (bit 0) = 0, lock (bit 1) = 0, read-policy field (bits 3:2) = 00, protect (bit 5) = 1.
- R2: A write (sel_i and we_i high at a clock edge) loads bit 0 and bits 3:2 from wdata_i. The new value is visible on rdata_o after that edge.
- R3: Writing 1 to bit 1 sets the lock. Writing 0 to bit 1 leaves it unchanged. Only reset clears it.
- R4: Bit 5 takes its value from the first write after reset. All later writes leave bit 5 unchanged until the next reset.
- R5: rdata_o bit 4 always equals top_swap_i. rdata_o bits 7:6 always read 0. Writes to bits 7:6 and bit 4 have no effect.
- R6: smi_o is high for exactly the one cycle after a write edge that takes bit 0 from 0 to 1. The pulse requires that the lock was already set or is set by that same write.
- R7: smi_o stays low for a write that keeps bit 0 at 1. It also stays low for a 0-to-1 write of bit 0 when the lock is neither set nor being set.
- R8: wr_permit_o = bit0 AND (NOT bit5 OR all_mgmt_i). It follows all_mgmt_i with no clock delay.
- R9: With sel_i low, no register bit changes, whatever we_i and wdata_i carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous platform reset |
| sel_i | input | 1 | Register select |
| we_i | input | 1 | Write strobe, qualified by sel_i |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Current register contents |
| all_mgmt_i | input | 1 | High when all processors are in management mode |
| top_swap_i | input | 1 | External top-swap status |
| smi_o | output | 1 | System-management interrupt pulse |
| wr_permit_o | output | 1 | Permits host writes to the firmware region |

## Verification
Two functions can fall in one cycle. A single write can set the lock and raise write-enable at once, and the interrupt must still fire. In the same way, the first write after reset both consumes the one-time protect update and changes write-enable, which moves the permit output. The bench issues such combined writes, including 0x03 from an unlocked state and a first write with bit 5 clear. A behavioural model predicts the lock, protect, interrupt and permit outcomes for every clock, and the bench compares read data, interrupt and permit against it after each edge.

// File: rtl/fwwp_pkg.sv
package fwwp_pkg;
  localparam int REG_W     = 8;
  localparam int B_WEN     = 0;
  localparam int B_LOCK    = 1;
  localparam int B_RCFG_LO = 2;
  localparam int B_RCFG_HI = 3;
  localparam int B_TSWAP   = 4;
  localparam int B_PROT    = 5;
  localparam int RCFG_W    = B_RCFG_HI - B_RCFG_LO + 1;
  localparam int RSV_W     = REG_W - B_PROT - 1;
  localparam logic PROT_RST = 1'b1;

  typedef struct packed {
    logic              prot;
    logic [RCFG_W-1:0] rcfg;
    logic              lock;
    logic              wen;
  } ctl_t;
endpackage

// File: rtl/fwwp_lock_unit.sv
module fwwp_lock_unit #(
  parameter logic PROT_RST = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic lock_d_i,
  input  logic prot_d_i,
  output logic lock_o,
  output logic prot_o
);
  logic lock_q, prot_q, prot_used_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q      <= 1'b0;
      prot_q      <= PROT_RST;
      prot_used_q <= 1'b0;
    end else if (wr_i) begin
      if (lock_d_i) lock_q <= 1'b1;  // set-only
      if (!prot_used_q) begin
        prot_q      <= prot_d_i;
        prot_used_q <= 1'b1;
      end
    end
  end

  assign lock_o = lock_q;
  assign prot_o = prot_q;
endmodule

// File: rtl/fwwp_smi_gen.sv
module fwwp_smi_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic wen_q_i,
  input  logic wen_d_i,
  input  logic lock_q_i,
  input  logic lock_d_i,
  output logic smi_o
);
  logic smi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) smi_q <= 1'b0;
    else         smi_q <= wr_i & ~wen_q_i & wen_d_i & (lock_q_i | lock_d_i);
  end

  assign smi_o = smi_q;
endmodule

// File: rtl/fwwp_permit.sv
module fwwp_permit (
  input  logic wen_i,
  input  logic prot_i,
  input  logic all_mgmt_i,
  output logic permit_o
);
  always_comb permit_o = wen_i & (~prot_i | all_mgmt_i);
endmodule

// File: rtl/fw_wp_ctrl.sv
module fw_wp_ctrl
  import fwwp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic             all_mgmt_i,
  input  logic             top_swap_i,
  output logic             smi_o,
  output logic             wr_permit_o
);
  logic wr;
  ctl_t ctl;
  logic wen_q;
  logic [RCFG_W-1:0] rcfg_q;
  logic lock_q, prot_q;
  logic unused_wdata;

  assign wr = sel_i & we_i;
  assign unused_wdata = ^{wdata_i[REG_W-1:B_PROT+1], wdata_i[B_TSWAP]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wen_q  <= 1'b0;
      rcfg_q <= '0;
    end else if (wr) begin
      wen_q  <= wdata_i[B_WEN];
      rcfg_q <= wdata_i[B_RCFG_HI:B_RCFG_LO];
    end
  end

  fwwp_lock_unit #(.PROT_RST(PROT_RST)) u_lock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr),
    .lock_d_i (wdata_i[B_LOCK]),
    .prot_d_i (wdata_i[B_PROT]),
    .lock_o   (lock_q),
    .prot_o   (prot_q)
  );

  fwwp_smi_gen u_smi (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr),
    .wen_q_i  (wen_q),
    .wen_d_i  (wdata_i[B_WEN]),
    .lock_q_i (lock_q),
    .lock_d_i (wdata_i[B_LOCK]),
    .smi_o    (smi_o)
  );

  fwwp_permit u_permit (
    .wen_i      (wen_q),
    .prot_i     (prot_q),
    .all_mgmt_i (all_mgmt_i),
    .permit_o   (wr_permit_o)
  );

  always_comb begin
    ctl.wen  = wen_q;
    ctl.lock = lock_q;
    ctl.rcfg = rcfg_q;
    ctl.prot = prot_q;
    rdata_o  = {{RSV_W{1'b0}}, ctl.prot, top_swap_i, ctl.rcfg, ctl.lock, ctl.wen};
  end
endmodule

// File: rtl/fw_wp_ctrl_chk.sv
module fw_wp_ctrl_chk
  import fwwp_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sel_i,
  input logic             we_i,
  input logic [REG_W-1:0] wdata_i,
  input logic [REG_W-1:0] rdata_o,
  input logic             all_mgmt_i,
  input logic             top_swap_i,
  input logic             smi_o,
  input logic             wr_permit_o
);
  // R3: lock is sticky
  a_r3_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[B_LOCK] |=> rdata_o[B_LOCK]);

  // R6: pulse lasts one cycle
  a_r6_smi_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smi_o |=> !smi_o);

  // R6: pulse only with write-enable and lock now set
  a_r6_smi_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smi_o |-> (rdata_o[B_WEN] && rdata_o[B_LOCK]));

  // R6: pulse follows a write of bit 0 = 1
  a_r6_smi_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(smi_o) |-> $past(sel_i && we_i && wdata_i[B_WEN]));

  // R8: permit requires write-enable and management qualification
  a_r8_permit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_permit_o |-> (rdata_o[B_WEN] && (!rdata_o[B_PROT] || all_mgmt_i)));

  // R9: nothing changes without select
  a_r9_no_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> $stable({rdata_o[B_PROT], rdata_o[B_RCFG_HI:0]}));

  // R5: reserved bits and mirrored status
  always @(posedge clk_i) begin
    if (rst_ni) begin
      a_r5_reserved: assert (rdata_o[REG_W-1:B_PROT+1] == '0);
      a_r5_tswap: assert (rdata_o[B_TSWAP] == top_swap_i);
    end
  end
endmodule

bind fw_wp_ctrl fw_wp_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sel_i       (sel_i),
  .we_i        (we_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .all_mgmt_i  (all_mgmt_i),
  .top_swap_i  (top_swap_i),
  .smi_o       (smi_o),
  .wr_permit_o (wr_permit_o)
);

// File: tb/fw_wp_ctrl_test.sv
module fw_wp_ctrl_test;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0, we = 1'b0, mgmt = 1'b0, tswap = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       smi, permit;

  int n_chk = 0, n_fail = 0;

  // behavioural model state
  bit       m_wen, m_lock, m_prot, m_prot_used, m_smi;
  bit [1:0] m_rcfg;

  fw_wp_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .all_mgmt_i(mgmt), .top_swap_i(tswap),
    .smi_o(smi), .wr_permit_o(permit)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic bit [7:0] exp_rd();
    return {2'b00, m_prot, tswap, m_rcfg, m_lock, m_wen};
  endfunction

  task automatic chk8(string tag, string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk8(tag, "rdata", rdata, exp_rd());
    chk8(tag, "smi", {7'd0, smi}, {7'd0, m_smi});
    chk8(tag, "permit", {7'd0, permit},
         {7'd0, m_wen & (~m_prot | mgmt)});
  endtask

  task automatic model_reset();
    m_wen = 0; m_lock = 0; m_prot = 1; m_prot_used = 0; m_smi = 0; m_rcfg = 0;
  endtask

  task automatic step(bit s, bit w, bit [7:0] d, bit mg, bit ts, string tag);
    @(negedge clk);
    sel = s; we = w; wdata = d; mgmt = mg; tswap = ts;
    m_smi = s && w && !m_wen && d[0] && (m_lock || d[1]);
    if (s && w) begin
      m_wen  = d[0];
      m_rcfg = d[3:2];
      if (d[1]) m_lock = 1;
      if (!m_prot_used) begin m_prot = d[5]; m_prot_used = 1; end
    end
    @(posedge clk);
    #(CLK_P/4);
    compare(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; sel = 0; we = 0; wdata = 0; mgmt = 0; tswap = 0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
    #(CLK_P/4);
    compare("R1");
    chk8("R1", "reset value", rdata, 8'h20);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    model_reset();
    do_reset();
    step(1, 1, 8'h21, 0, 0, "R2");  // first write keeps protect, wen on
    chk8("R7", "no smi without lock", {7'd0, smi}, 8'd0);
    step(0, 0, 8'h00, 1, 0, "R8");  // all-in-management permits
    step(0, 0, 8'h00, 0, 0, "R8");
    step(1, 1, 8'h0D, 0, 0, "R4");  // protect clear ignored after first write
    chk8("R4", "protect held", {7'd0, rdata[5]}, 8'd1);
    step(0, 1, 8'hFF, 0, 1, "R9");  // no select
    step(1, 1, 8'hD0, 0, 1, "R5");  // reserved and status bits
    chk8("R5", "upper bits", rdata & 8'hD0, 8'h10);
    step(1, 1, 8'h03, 0, 0, "R6");  // lock and wen set in one write
    chk8("R6", "smi combined", {7'd0, smi}, 8'd1);
    step(0, 0, 8'h00, 0, 0, "R6");  // pulse ends
    step(1, 1, 8'h03, 0, 0, "R7");  // rewrite of 1
    step(1, 1, 8'h00, 0, 0, "R3");  // lock stays
    chk8("R3", "lock sticky", {7'd0, rdata[1]}, 8'd1);
    step(1, 1, 8'h01, 1, 0, "R6");  // old lock
    step(0, 0, 8'h00, 1, 0, "R6");

    do_reset();
    step(1, 1, 8'h01, 0, 0, "R7");  // unlocked rise, protect cleared by first write
    step(0, 0, 8'h00, 0, 0, "R8");
    chk8("R8", "permit unprotected", {7'd0, permit}, 8'd1);
    step(1, 1, 8'h20, 0, 0, "R4");
    step(1, 1, 8'h01, 0, 1, "R7");

    for (int i = 0; i < 300; i++) begin
      step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           8'($urandom), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R2");
      if (i == 150) do_reset();
    end
    finish_run();
  end
endmodule